// File: doc/BRIEF.md
# Carry and Overflow ALU

This block is a 32-bit add/subtract unit that shares one status bit, called T, between four arithmetic operations. Two operations chain through T: add-with-carry and subtract-with-borrow both consume the present T as an incoming carry or borrow, and then write the new carry or borrow back into T. The other two operations ignore T as an input and write signed overflow into it. This lets software build wide additions and subtractions one word at a time, and test for two's-complement overflow, using the same single-bit flag.

The result is combinational and appears in the same cycle as the operands. T is a registered two-state machine with the states `TF_CLEAR` and `TF_SET`. Reset forces `TF_CLEAR`. On each rising edge with `op_valid` high the machine takes the transition chosen by the flag logic: either set (to `TF_SET`) or clear (to `TF_CLEAR`). With `op_valid` low it takes the hold transition and stays in its current state.

Opcode encoding on `op_sel`: `2'b00` add-with-carry, `2'b01` add-with-overflow, `2'b10` subtract-with-borrow, `2'b11` subtract-with-overflow. Throughout, A is `opnd_a` and B is `opnd_b`.

Top module: `carry_ovf_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, T (`t_flag`) reads 0 until a valid operation sets it.
- R2: With `op_sel`=2'b00, `result` equals (A + B + T) modulo 2^32.
- R3: After a valid `op_sel`=2'b00 cycle, T becomes 1 exactly when A + B + T is 2^32 or more. This is an unsigned carry out of bit 31, whether it comes from the operand sum or from adding T.
- R4: With `op_sel`=2'b10, `result` equals (B − A − T) modulo 2^32.
- R5: After a valid `op_sel`=2'b10 cycle, T becomes 1 exactly when B < A + T, taken as unsigned (a borrow).
- R6: With `op_sel`=2'b01, `result` equals (A + B) modulo 2^32, whatever T holds. After a valid cycle, T becomes 1 only when bit 31 of A equals bit 31 of B and bit 31 of the result differs from them; otherwise T becomes 0.
- R7: With `op_sel`=2'b11, `result` equals (B − A) modulo 2^32, whatever T holds. After a valid cycle, T becomes 1 only when bit 31 of A differs from bit 31 of B and bit 31 of the result differs from bit 31 of B; otherwise T becomes 0.
- R8: On any rising edge with `op_valid` low, T keeps its value, whatever the operands and opcode are.
- R9: `result` follows the inputs in the same cycle. T changes only at the rising edge that samples `op_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; T updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of T |
| op_valid | input | 1 | Strobe; T is written only on a cycle where this is high |
| op_sel | input | 2 | Operation select (encoding above) |
| opnd_a | input | 32 | Operand A (addend, or subtrahend for subtraction) |
| opnd_b | input | 32 | Operand B (addend, or minuend for subtraction) |
| result | output | 32 | Combinational 32-bit wrapped result |
| t_flag | output | 1 | Current T flag |

## Verification
The hardest cases to reach are the ones where the carry or borrow comes only from the folded-in T bit and not from the operands. Examples are all-ones plus zero with T set, or zero minus zero with T set. They are hard because T must first be driven to a known value through the ports. Before each vector, the bench runs a conditioning operation that forces T: an add-with-carry of two all-ones words sets it, and an add-with-overflow of two zeros clears it. Only then does it apply the vector under test. The same conditioning step is used to show that the overflow operations ignore a set T, and that strobe-low cycles do not disturb T.

// File: rtl/coalu_pkg.sv
package coalu_pkg;

    // Operation codes; bit 1 selects subtraction, bit 0 selects overflow mode
    typedef enum logic [1:0] {
        OP_ADDC = 2'b00,
        OP_ADDV = 2'b01,
        OP_SUBC = 2'b10,
        OP_SUBV = 2'b11
    } alu_op_e;

    // The two states of the T status machine
    typedef enum logic {
        TF_CLEAR = 1'b0,
        TF_SET   = 1'b1
    } tflag_state_e;

endpackage

// File: rtl/coalu_addsub.sv
module coalu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_x,     // addend or subtrahend
    input  logic [W-1:0] opnd_y,     // addend or minuend
    input  logic         do_sub,
    input  logic         cin_t,      // T bit already gated by the opcode
    output logic [W-1:0] sum,
    output logic         carry_borrow
);
    localparam int WX = W + 1;

    logic [W-1:0] x_eff;
    logic         c_eff;
    logic [WX-1:0] wide;

    // Subtraction y - x - t is done as y + ~x + (1 - t); a carry out of the
    // top bit then means that no borrow occurred.
    always_comb begin
        x_eff = do_sub ? ~opnd_x : opnd_x;
        c_eff = do_sub ? ~cin_t : cin_t;
        wide  = {1'b0, opnd_y} + {1'b0, x_eff} + {{W{1'b0}}, c_eff};
    end

    assign sum          = wide[W-1:0];
    assign carry_borrow = do_sub ? ~wide[W] : wide[W];

endmodule

// File: rtl/coalu_flag_next.sv
module coalu_flag_next
    import coalu_pkg::*;
(
    input  alu_op_e op,
    input  logic    sign_a,
    input  logic    sign_b,
    input  logic    sign_r,
    input  logic    cb,          // carry (add) or borrow (sub)
    output logic    flag_set
);
    always_comb begin
        flag_set = 1'b0;
        unique case (op)
            OP_ADDC: flag_set = cb;
            OP_SUBC: flag_set = cb;
            // like-signed addends whose sum flips sign
            OP_ADDV: flag_set = (sign_a == sign_b) && (sign_r != sign_a);
            // unlike-signed operands whose difference leaves the minuend's sign
            OP_SUBV: flag_set = (sign_a != sign_b) && (sign_r != sign_b);
            default: flag_set = 1'b0;
        endcase
    end
endmodule

// File: rtl/carry_ovf_alu.sv
module carry_ovf_alu
    import coalu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         t_flag
);
    localparam int MSB = W - 1;

    alu_op_e      op;
    logic         do_sub;
    logic         use_t;
    logic         cb;
    logic         flag_set;
    tflag_state_e t_state, t_state_nxt;

    assign op = alu_op_e'(op_sel);

    // Opcode decode
    always_comb begin
        do_sub = 1'b0;
        use_t  = 1'b0;
        unique case (op)
            OP_ADDC: begin do_sub = 1'b0; use_t = 1'b1; end
            OP_ADDV: begin do_sub = 1'b0; use_t = 1'b0; end
            OP_SUBC: begin do_sub = 1'b1; use_t = 1'b1; end
            OP_SUBV: begin do_sub = 1'b1; use_t = 1'b0; end
            default: begin do_sub = 1'b0; use_t = 1'b0; end
        endcase
    end

    coalu_addsub #(.W(W)) addsub_i (
        .opnd_x       (opnd_a),
        .opnd_y       (opnd_b),
        .do_sub       (do_sub),
        .cin_t        (use_t & t_flag),
        .sum          (result),
        .carry_borrow (cb)
    );

    coalu_flag_next flag_i (
        .op       (op),
        .sign_a   (opnd_a[MSB]),
        .sign_b   (opnd_b[MSB]),
        .sign_r   (result[MSB]),
        .cb       (cb),
        .flag_set (flag_set)
    );

    // Next-state process: hold, set or clear
    always_comb begin
        t_state_nxt = t_state;
        if (op_valid) begin
            unique case (flag_set)
                1'b1: t_state_nxt = TF_SET;
                1'b0: t_state_nxt = TF_CLEAR;
                default: t_state_nxt = TF_CLEAR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) t_state <= TF_CLEAR;
        else        t_state <= t_state_nxt;
    end

    // Output process
    always_comb begin
        unique case (t_state)
            TF_SET:   t_flag = 1'b1;
            TF_CLEAR: t_flag = 1'b0;
            default:  t_flag = 1'b0;
        endcase
    end

    // R8: no strobe, no change of T
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(t_flag));

    // R3: a wrapped sum below A can only come from a carry
    p_addc_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'b00 && result < opnd_a) |=> t_flag);

    // R5: a wrapped difference above B can only come from a borrow
    p_subc_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'b10 && result > opnd_b) |=> t_flag);

    // R6: unlike-signed addends never overflow
    p_addv_mixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'b01 && opnd_a[MSB] != opnd_b[MSB]) |=> !t_flag);

    // R7: like-signed operands never overflow on subtraction
    p_subv_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'b11 && opnd_a[MSB] == opnd_b[MSB]) |=> !t_flag);

endmodule

// File: tb/carry_ovf_alu_tb_top.sv
module carry_ovf_alu_tb_top;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        tin;
        logic [31:0] res;
        logic        tout;
    } vec_t;

    localparam int NV = 19;
    // op: 00 add-carry (R2,R3), 01 add-ovf (R6), 10 sub-borrow (R4,R5), 11 sub-ovf (R7)
    localparam vec_t VECS [0:NV-1] = '{
        '{2'b00, 32'h0000_0001, 32'h0000_0002, 1'b0, 32'h0000_0003, 1'b0},
        '{2'b00, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1},
        '{2'b00, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1},
        '{2'b00, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 32'h0000_0000, 1'b1},
        '{2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1, 32'h8000_0001, 1'b0},
        '{2'b01, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1, 32'h8000_0000, 1'b1},
        '{2'b01, 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1},
        '{2'b01, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b0},
        '{2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFE, 1'b0},
        '{2'b10, 32'h0000_0001, 32'h0000_0005, 1'b0, 32'h0000_0004, 1'b0},
        '{2'b10, 32'h0000_0005, 32'h0000_0001, 1'b0, 32'hFFFF_FFFC, 1'b1},
        '{2'b10, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 1'b1},
        '{2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1},
        '{2'b10, 32'h0000_0001, 32'h0000_0002, 1'b1, 32'h0000_0000, 1'b0},
        '{2'b11, 32'h0000_0001, 32'h8000_0000, 1'b1, 32'h7FFF_FFFF, 1'b1},
        '{2'b11, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b0, 32'h8000_0000, 1'b1},
        '{2'b11, 32'h0000_0001, 32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 1'b0},
        '{2'b11, 32'h8000_0000, 32'h0000_0000, 1'b0, 32'h8000_0000, 1'b1},
        '{2'b11, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'h8000_0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        t_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    carry_ovf_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .t_flag(t_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation from a falling edge; the strobe is dropped a cycle later
    task automatic drive(input logic v, input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
    endtask

    // Force T through the ports: all-ones add-carry sets, zero add-ovf clears
    task automatic force_t(input logic v);
        if (v) drive(1'b1, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        else   drive(1'b1, 2'b01, 32'h0, 32'h0);
    endtask

    function automatic string res_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R2";
            2'b10: return "R4";
            2'b01: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic string flag_tag(input logic [1:0] op);
        case (op)
            2'b00: return "R3";
            2'b10: return "R5";
            2'b01: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 T in reset", {31'b0, t_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 T after reset", {31'b0, t_flag}, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            force_t(VECS[i].tin);
            drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b);
            #1;
            check(res_tag(VECS[i].op), result, VECS[i].res);
            if (i < 4) check("R9 T unchanged before edge", {31'b0, t_flag}, {31'b0, VECS[i].tin});
            @(negedge clk);
            op_valid = 1'b0;
            check(flag_tag(VECS[i].op), {31'b0, t_flag}, {31'b0, VECS[i].tout});
        end

        // R8: strobe low with T set, inputs that would clear T
        force_t(1'b1);
        drive(1'b0, 2'b01, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        check("R8 hold set", {31'b0, t_flag}, 32'h1);
        // R8: strobe low with T clear, inputs that would set T
        force_t(1'b0);
        drive(1'b0, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        check("R8 hold clear", {31'b0, t_flag}, 32'h0);
        // R2: result still follows inputs with strobe low, using T=0
        #1;
        check("R2 result without strobe", result, 32'hFFFF_FFFE);

        // R1: reset in mid-run clears a set T
        force_t(1'b1);
        @(negedge clk);
        op_valid = 1'b0;
        check("R3 T set before reset", {31'b0, t_flag}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", {31'b0, t_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule